// File: doc/BRIEF.md
# Buck Stage PWM Modulator with Non-Overlap Timing

This block turns a duty command into the two gate enables of a synchronous buck power stage. A free-running counter spans one switching period of `PERIOD` clock cycles; the nominal setting of 333 cycles at 100 MHz gives about 300 kHz. The command is an unsigned count of clock cycles of high-side on-time. The block latches it once per period and limits it to `MAX_PCT` percent of the period, 90 by default. It then places the high-side pulse and the low-side pulse so that `DEAD` idle cycles separate them at both handovers. The default of 2 cycles is about 20 ns.

A low enable input or a fault input turns both gates off on the next clock edge. Disabling only gates the outputs. Switching comes back on a period boundary, and only if enable was high on the last cycle of the period before. A fault is latched, and only reset clears it. A one-cycle strobe marks the first output cycle of every period.

Position p in a period counts the clock cycles since the strobe, so the strobe cycle is p = 0. Let d be the latched, clamped command. The high side is on for p in [DEAD, DEAD+d). The low side is on for p in [d+2·DEAD, PERIOD). The parameters must satisfy floor(PERIOD·MAX_PCT/100) + 2·DEAD ≤ PERIOD.

Top module: `buck_pwm_core`

## Requirements
- R1: `period_start` is high for exactly one cycle at position 0 of every period, and periods are `PERIOD` cycles long. The first strobe appears in the first cycle after reset is released.
- R2: While reset is low, both gates and `period_start` are low. The first period after reset keeps both gates off, and switching starts with the second period. A reset also clears a latched fault.
- R3: In an enabled period with latched duty d, `hs_gate` is high exactly for positions DEAD ≤ p < DEAD+d. With d = 0 it stays low for the whole period.
- R4: In an enabled period, `ls_gate` is high exactly for positions d+2·DEAD ≤ p < PERIOD.
- R5: The two gates are never high together. Before either gate rises, the other has been low for at least DEAD consecutive cycles.
- R6: The latched duty d is the smaller of `duty_cmd` and floor(PERIOD·MAX_PCT/100). A command above that ceiling gives a high-side on-time equal to the ceiling.
- R7: `duty_cmd` is sampled only on the clock edge that produces position PERIOD−1. A change at any other time does not affect the period in progress.
- R8: When `enable` is low at a clock edge, both gates are low after that edge. Switching resumes only at a period start whose preceding position-(PERIOD−1) edge saw `enable` high.
- R9: When `fault` is high at a clock edge, both gates are low after that edge. They stay low after `fault` returns low, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_cmd | input | DUTY_W | High-side on-time request in clock cycles (unsigned) |
| enable | input | 1 | Run request; low acts as shutdown |
| fault | input | 1 | Under-voltage fault; latched until reset |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |
| period_start | output | 1 | One-cycle strobe at position 0 of each period |

## Verification
The bench builds the block with PERIOD = 50, DEAD = 2 and DUTY_W = 6, so the duty ceiling is 45 cycles. With these values every command from 0 to 63 fits into one sweep of 64 short periods. The sweep reaches the zero-duty period, the ceiling where the low-side window shrinks to a single cycle, and 18 commands that must be clamped. The short period also leaves room for mid-period command changes, shutdown windows, a latched fault and a second reset, all within a few thousand cycles. Every output cycle is compared with an arithmetic model of the windows.

// File: rtl/buck_pwm_core.sv
module buck_pwm_core #(
  parameter int PERIOD  = 333,
  parameter int DEAD    = 2,
  parameter int DUTY_W  = 9,
  parameter int MAX_PCT = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty_cmd,
  input  logic              enable,
  input  logic              fault,
  output logic              hs_gate,
  output logic              ls_gate,
  output logic              period_start
);

  localparam int CNT_W  = $clog2(PERIOD);
  localparam int MAX_ON = PERIOD * MAX_PCT / 100;
  localparam int VW     = ((CNT_W > DUTY_W) ? CNT_W : DUTY_W) + 2;
  localparam logic [VW-1:0] DEAD_V = VW'(DEAD);
  localparam logic [VW-1:0] MAX_V  = VW'(MAX_ON);
  localparam logic [VW-1:0] LAST_V = VW'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic [VW-1:0]    duty_q;
  logic             run_q, flt_q;

  logic [VW-1:0] pos_v, cmd_v, cmd_clamped;
  logic          wrap, gate_ok, hs_win, ls_win;

  assign pos_v       = VW'(cnt);
  assign cmd_v       = VW'(duty_cmd);
  assign cmd_clamped = (cmd_v > MAX_V) ? MAX_V : cmd_v;
  assign wrap        = (pos_v == LAST_V);
  assign gate_ok     = run_q & enable & ~fault & ~flt_q;
  assign hs_win      = (pos_v >= DEAD_V) && (pos_v < duty_q + DEAD_V);
  assign ls_win      = (pos_v >= duty_q + DEAD_V + DEAD_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt          <= '0;
      duty_q       <= '0;
      run_q        <= 1'b0;
      flt_q        <= 1'b0;
      hs_gate      <= 1'b0;
      ls_gate      <= 1'b0;
      period_start <= 1'b0;
    end else begin
      cnt          <= wrap ? '0 : cnt + 1'b1;
      period_start <= (cnt == '0);
      hs_gate      <= gate_ok & hs_win;
      ls_gate      <= gate_ok & ls_win;
      flt_q        <= flt_q | fault;
      if (wrap) begin
        duty_q <= cmd_clamped;
        run_q  <= enable & ~fault & ~flt_q;
      end else if (!enable || fault) begin
        run_q  <= 1'b0;
      end
    end
  end

  logic [VW-1:0] hs_low, ls_low, hs_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low  <= DEAD_V;
      ls_low  <= DEAD_V;
      hs_high <= '0;
    end else begin
      hs_low  <= hs_gate ? '0 : ((hs_low < DEAD_V) ? hs_low + 1'b1 : hs_low);
      ls_low  <= ls_gate ? '0 : ((ls_low < DEAD_V) ? ls_low + 1'b1 : ls_low);
      hs_high <= !hs_gate ? '0 : ((hs_high < MAX_V) ? hs_high + 1'b1 : hs_high);
    end
  end

  // R1
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  // R5
  hs_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (ls_low >= DEAD_V));

  // R5
  ls_dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (hs_low >= DEAD_V));

  // R6
  max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (hs_high < MAX_V));

  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> (cnt == '0));

  // R8
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_gate && !ls_gate));

  // R9
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!hs_gate && !ls_gate));

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> (!hs_gate && !ls_gate));

endmodule

// File: tb/tb_buck_pwm_core.sv
module tb_buck_pwm_core;
  localparam int P     = 50;
  localparam int D     = 2;
  localparam int W     = 6;
  localparam int MAXON = P * 90 / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cmd = '0;
  logic en = 1'b0;
  logic fin = 1'b0;
  logic hs, ls, ps;

  always #5 clk = ~clk;

  buck_pwm_core #(.PERIOD(P), .DEAD(D), .DUTY_W(W), .MAX_PCT(90)) dut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(cmd), .enable(en), .fault(fin),
    .hs_gate(hs), .ls_gate(ls), .period_start(ps));

  int checks = 0;
  int errors = 0;
  int opos = -1;
  int cur_d = 0, pend_d = 0;
  bit cur_run = 0, pend_run = 0, flt = 0, exp_ok = 0;
  bit exp_hs, exp_ls, exp_ps;
  string tag_hs = "R3", tag_ls = "R4";
  bit len_on = 0, full = 0;
  int hs_len = 0, ls_len = 0, hs_low = D, ls_low = D;
  bit prev_hs = 0, prev_ls = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at pos %0d: actual %0d expected %0d", tag, opos, act, exp);
    end
  endtask

  task automatic model_reset();
    opos = -1; cur_d = 0; pend_d = 0; cur_run = 0; pend_run = 0; flt = 0;
    hs_low = D; ls_low = D; prev_hs = 0; prev_ls = 0;
  endtask

  task automatic step();
    @(posedge clk);
    opos = (opos + 1) % P;
    if (opos == 0) begin
      cur_d = pend_d; cur_run = pend_run; full = 1; hs_len = 0; ls_len = 0;
    end
    if (!en || fin) cur_run = 0;
    if (opos == P - 1) begin
      pend_d = (int'(cmd) > MAXON) ? MAXON : int'(cmd);
      pend_run = en && !fin && !flt;
    end
    exp_ok = cur_run && en && !fin && !flt;
    flt = flt || fin;
    exp_hs = exp_ok && opos >= D && opos < cur_d + D;
    exp_ls = exp_ok && opos >= cur_d + 2 * D;
    exp_ps = (opos == 0);
    full = full && exp_ok;
    @(negedge clk);
    check(tag_hs, hs, exp_hs);
    check(tag_ls, ls, exp_ls);
    check("R1", ps, exp_ps);
    check("R5", hs && ls, 0);
    if (hs && !prev_hs) check("R5", ls_low >= D, 1);
    if (ls && !prev_ls) check("R5", hs_low >= D, 1);
    hs_low = hs ? 0 : hs_low + 1;
    ls_low = ls ? 0 : ls_low + 1;
    prev_hs = hs; prev_ls = ls;
    if (hs) hs_len++;
    if (ls) ls_len++;
    if (len_on && opos == P - 1 && full) begin
      check("R6", hs_len, cur_d);
      check("R4", ls_len, P - cur_d - 2 * D);
    end
  endtask

  task automatic wait_pos(int p);
    do step(); while (opos != p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check("R2", hs, 0); check("R2", ls, 0); check("R2", ps, 0);
    en = 1'b1; cmd = 6'd10;
    rst_n = 1'b1;
    tag_hs = "R2"; tag_ls = "R2";
    wait_pos(P - 1);
    tag_hs = "R3"; tag_ls = "R4"; len_on = 1;
    for (int c = 0; c < 64; c++) begin
      wait_pos(10);
      cmd = W'(c);
      tag_hs = (cur_d == MAXON) ? "R6" : "R3";
    end
    wait_pos(P - 1);
    wait_pos(P - 1);
    // R7: mid-period changes apply only from the next period
    tag_hs = "R7"; tag_ls = "R7";
    cmd = 6'd20;
    wait_pos(P - 1);
    wait_pos(3); cmd = 6'd5;
    wait_pos(25); cmd = 6'd33;
    wait_pos(P - 1);
    wait_pos(P - 3); cmd = 6'd0;
    wait_pos(P - 1);
    wait_pos(P - 1);
    // R8: shutdown mid-period, re-enable mid-period
    tag_hs = "R8"; tag_ls = "R8"; cmd = 6'd15;
    wait_pos(20); en = 1'b0;
    repeat (40) step();
    en = 1'b1;
    wait_pos(P - 1);
    wait_pos(P - 1);
    wait_pos(P - 2); en = 1'b0;
    step(); en = 1'b1;
    wait_pos(P - 1);
    wait_pos(P - 1);
    // R9: one-cycle fault latches off
    tag_hs = "R9"; tag_ls = "R9";
    wait_pos(15); fin = 1'b1;
    step(); fin = 1'b0;
    repeat (3 * P) step();
    // R2: reset clears the fault, switching restarts after one idle period
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check("R2", hs, 0); check("R2", ls, 0); check("R2", ps, 0);
    cmd = 6'd30;
    rst_n = 1'b1;
    tag_hs = "R2"; tag_ls = "R2";
    wait_pos(P - 1);
    wait_pos(P - 1);
    wait_pos(P - 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule